// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel

This block is one DMA channel that walks a chain of transfer descriptors kept in memory. Software programs the pointer to the first descriptor, a starting destination address and the handshake configuration. It then sets the global enable and writes 1 to the channel enable. The channel reads each five-word descriptor over a simple memory master port. It moves that block one element at a time (a read followed by a write) and groups the elements into single or chunk transactions. When the block ends, it writes the completion flag back into the descriptor in memory, then follows the next pointer until it reaches a descriptor whose next pointer is zero.

The source address is reloaded from every descriptor. The destination is one contiguous region: the destination word in each descriptor is fetched but thrown away, so the running destination address carries over from one block to the next. Each endpoint can be paced by a request/acknowledge pair with a peripheral, or it can run freely as memory. When the chain finishes, the channel raises an interrupt that is cleared by reading the status register.

Top module: `lldma_channel`

## Requirements
- R1: A write of 1 in bit 0 to the channel-enable register (offset 1) starts the channel only if bit 0 of the global-enable register (offset 0) is set and the channel is idle. Otherwise no memory request is made and the channel-enable register reads 0.
- R2: On each descriptor load, five words are read at the descriptor pointer plus 0, 4, 8, 12 and 16, in that order. These words are the source address, the destination address, the next pointer, control word A and control word B. The first load uses the pointer in register offset 2.
- R3: The destination word of a descriptor has no effect. Destination writes continue from the register at offset 3 across all blocks, and that register reads back the running value after the chain ends.
- R4: The source address is reloaded from each descriptor and moves by the source width in bytes after every element. The width is in control word A bits 17:16, coded 0 = byte, 1 = halfword, 2 = word. The mode is in control word B bits 1:0, coded 0 = increment, 1 = decrement, 2 = fixed.
- R5: The destination has its own width (control word A bits 19:18) and mode (control word B bits 3:2), with the same codes as R4. Each element read at the source width is written zero-extended or truncated to the destination width.
- R6: Control word A bits 15:0 give the element count of the block. When the count reaches zero, control word A is written back to descriptor offset 12 with bit 31 (done) set and all other bits unchanged.
- R7: A non-zero next pointer causes a load of the descriptor it points to. A zero next pointer ends the chain after that block's write-back.
- R8: When configuration bit 0 (source) or bit 1 (destination) is 1, that peripheral's request must be high before a transaction starts. The channel gives it a one-cycle acknowledge at the end of every transaction. A transaction is a chunk of 2^(control word B bits 6:4) elements while at least that many remain, and otherwise a single element.
- R9: With the configuration bit at 0, that endpoint's request is ignored and its acknowledge stays low.
- R10: At the end of the chain, status bit 0 (offset 5) is set, the interrupt output goes high, and the channel-enable register reads 0.
- R11: A read of the status register (reg_re at offset 5) clears bit 0 and the interrupt. If the chain ends in the same cycle as such a read, the bit is set anyway.
- R12: After reset, the channel is idle, the interrupt, memory request and acknowledges are low, and all registers read 0.
- R13: A memory request keeps its address, direction and size until it is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (side effect on status) |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_size | output | 2 | Access size code (0 byte, 1 half, 2 word) |
| mem_wdata | output | 32 | Right-aligned write data |
| mem_rdata | input | 32 | Right-aligned read data, valid with grant |
| mem_gnt | input | 1 | Access completes in a cycle with req and gnt |
| src_req | input | 1 | Source peripheral request |
| src_ack | output | 1 | Source peripheral acknowledge pulse |
| dst_req | input | 1 | Destination peripheral request |
| dst_ack | output | 1 | Destination peripheral acknowledge pulse |
| irq | output | 1 | Chain-complete interrupt |

## Verification
Two events can land in the same clock edge. One is the chain-complete event, which sets the status bit. The other is a status read, which clears it. The bench holds reg_re high on the status offset for the whole run of a chain, so the completion edge always falls in a clearing cycle. It then expects the interrupt to be seen high for at least one cycle and to be low again once the read continues. The sweeps over width and mode pairs, and the chained and handshaked runs, are judged by comparing the whole memory image with an element-by-element model held in the bench. This check also covers the done flags, which land inside the descriptors.

// File: rtl/lldma_pkg.sv
package lldma_pkg;
    localparam int ADDR_W     = 32;
    localparam int WORD_W     = 32;
    localparam int CNT_W      = 16;
    localparam int DESC_WORDS = 5;
    localparam int IDX_W      = $clog2(DESC_WORDS + 1);

    // descriptor word indices
    localparam int DW_SRC  = 0;
    localparam int DW_DST  = 1;
    localparam int DW_NEXT = 2;
    localparam int DW_CA   = 3;
    localparam int DW_CB   = 4;

    // register offsets
    localparam logic [2:0] RA_GEN   = 3'd0;
    localparam logic [2:0] RA_CHEN  = 3'd1;
    localparam logic [2:0] RA_DSCR  = 3'd2;
    localparam logic [2:0] RA_DADDR = 3'd3;
    localparam logic [2:0] RA_CFG   = 3'd4;
    localparam logic [2:0] RA_ISR   = 3'd5;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_CHK, ST_WAIT, ST_RD, ST_WR, ST_ACK, ST_WB
    } eng_state_e;

    typedef struct packed {
        logic             done;
        logic [10:0]      rsvd;
        logic [1:0]       dst_w;
        logic [1:0]       src_w;
        logic [CNT_W-1:0] count;
    } ctrl_a_t;

    typedef struct packed {
        logic [2:0] chunk_log;
        logic [1:0] dst_mode;
        logic [1:0] src_mode;
    } ctrl_b_t;

    function automatic logic [ADDR_W-1:0] addr_step(logic [1:0] w, logic [1:0] m);
        logic [ADDR_W-1:0] nb;
        nb = (w == 2'd0) ? ADDR_W'(1) : (w == 2'd1) ? ADDR_W'(2) : ADDR_W'(4);
        case (m)
            2'd0:    return nb;
            2'd1:    return -nb;
            default: return '0;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] width_mask(logic [1:0] w);
        case (w)
            2'd0:    return WORD_W'(32'h0000_00FF);
            2'd1:    return WORD_W'(32'h0000_FFFF);
            default: return '1;
        endcase
    endfunction
endpackage

// File: rtl/lldma_regs.sv
module lldma_regs
    import lldma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [2:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              busy,
    input  logic              chain_done,
    input  logic [ADDR_W-1:0] daddr,
    output logic              start,
    output logic              daddr_we,
    output logic              gen_en,
    output logic [ADDR_W-1:0] dscr_ptr,
    output logic              src_hw,
    output logic              dst_hw,
    output logic              irq
);
    logic [1:0] cfg_q;
    logic       isr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gen_en   <= 1'b0;
            dscr_ptr <= '0;
            cfg_q    <= '0;
            isr_q    <= 1'b0;
        end else begin
            if (reg_we && reg_addr == RA_GEN)  gen_en   <= reg_wdata[0];
            if (reg_we && reg_addr == RA_DSCR) dscr_ptr <= reg_wdata[ADDR_W-1:0];
            if (reg_we && reg_addr == RA_CFG)  cfg_q    <= reg_wdata[1:0];
            // completion outranks a clearing read in the same cycle
            if (chain_done)                           isr_q <= 1'b1;
            else if (reg_re && reg_addr == RA_ISR)    isr_q <= 1'b0;
        end
    end

    assign start    = reg_we && reg_addr == RA_CHEN && reg_wdata[0] && gen_en && !busy;
    assign daddr_we = reg_we && reg_addr == RA_DADDR;
    assign src_hw   = cfg_q[0];
    assign dst_hw   = cfg_q[1];
    assign irq      = isr_q;

    always_comb begin
        case (reg_addr)
            RA_GEN:   reg_rdata = WORD_W'(gen_en);
            RA_CHEN:  reg_rdata = WORD_W'(busy);
            RA_DSCR:  reg_rdata = WORD_W'(dscr_ptr);
            RA_DADDR: reg_rdata = WORD_W'(daddr);
            RA_CFG:   reg_rdata = WORD_W'(cfg_q);
            RA_ISR:   reg_rdata = WORD_W'(isr_q);
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/lldma_engine.sv
module lldma_engine
    import lldma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_ptr,
    input  logic              daddr_we,
    input  logic [ADDR_W-1:0] daddr_wdata,
    input  logic              src_hw,
    input  logic              dst_hw,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_gnt,
    input  logic              src_req,
    input  logic              dst_req,
    output logic              src_ack,
    output logic              dst_ack,
    output logic              busy,
    output logic              chain_done,
    output logic [ADDR_W-1:0] daddr
);
    eng_state_e        st;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] ptr, nxt, saddr;
    logic [CNT_W-1:0]  cnt, tcnt;
    logic [WORD_W-1:0] data_q;
    ctrl_a_t           ca_q;
    ctrl_b_t           cb_q;

    logic [CNT_W-1:0]  chunk_len;
    logic              hs_ok;

    assign chunk_len = CNT_W'(1) << cb_q.chunk_log;
    assign hs_ok     = (!src_hw || src_req) && (!dst_hw || dst_req);
    assign busy      = (st != ST_IDLE);
    assign src_ack   = (st == ST_ACK) && src_hw;
    assign dst_ack   = (st == ST_ACK) && dst_hw;
    assign chain_done = (st == ST_WB) && mem_gnt && (nxt == '0);

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_size  = 2'd2;
        mem_wdata = '0;
        case (st)
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = ptr + ADDR_W'({idx, 2'b00});
            end
            ST_RD: begin
                mem_req  = 1'b1;
                mem_addr = saddr;
                mem_size = ca_q.src_w;
            end
            ST_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = daddr;
                mem_size  = ca_q.dst_w;
                mem_wdata = data_q & width_mask(ca_q.dst_w);
            end
            ST_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ptr + ADDR_W'(DW_CA * 4);
                mem_wdata = {1'b1, ca_q[WORD_W-2:0]};
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            idx    <= '0;
            ptr    <= '0;
            nxt    <= '0;
            saddr  <= '0;
            daddr  <= '0;
            cnt    <= '0;
            tcnt   <= '0;
            data_q <= '0;
            ca_q   <= '0;
            cb_q   <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (daddr_we) daddr <= daddr_wdata;
                    if (start) begin
                        ptr <= start_ptr;
                        idx <= '0;
                        st  <= ST_FETCH;
                    end
                end
                ST_FETCH: if (mem_gnt) begin
                    // the destination word is read and dropped
                    case (int'(idx))
                        DW_SRC:  saddr <= mem_rdata;
                        DW_NEXT: nxt   <= mem_rdata;
                        DW_CA: begin
                            ca_q <= mem_rdata;
                            cnt  <= mem_rdata[CNT_W-1:0];
                        end
                        DW_CB:   cb_q  <= mem_rdata[6:0];
                        default: ;
                    endcase
                    idx <= idx + 1'b1;
                    if (int'(idx) == DESC_WORDS - 1) st <= ST_CHK;
                end
                ST_CHK: begin
                    if (cnt == '0) st <= ST_WB;
                    else begin
                        tcnt <= (cnt >= chunk_len) ? chunk_len : CNT_W'(1);
                        st   <= ST_WAIT;
                    end
                end
                ST_WAIT: if (hs_ok) st <= ST_RD;
                ST_RD: if (mem_gnt) begin
                    data_q <= mem_rdata & width_mask(ca_q.src_w);
                    saddr  <= saddr + addr_step(ca_q.src_w, cb_q.src_mode);
                    st     <= ST_WR;
                end
                ST_WR: if (mem_gnt) begin
                    daddr <= daddr + addr_step(ca_q.dst_w, cb_q.dst_mode);
                    cnt   <= cnt - 1'b1;
                    tcnt  <= tcnt - 1'b1;
                    st    <= (tcnt == CNT_W'(1)) ? ST_ACK : ST_RD;
                end
                ST_ACK: st <= ST_CHK;
                ST_WB: if (mem_gnt) begin
                    if (nxt == '0) st <= ST_IDLE;
                    else begin
                        ptr <= nxt;
                        idx <= '0;
                        st  <= ST_FETCH;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lldma_channel.sv
module lldma_channel
    import lldma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [2:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_gnt,
    input  logic              src_req,
    output logic              src_ack,
    input  logic              dst_req,
    output logic              dst_ack,
    output logic              irq
);
    logic              busy, chain_done, start, daddr_we, gen_en, src_hw, dst_hw;
    logic [ADDR_W-1:0] daddr, dscr_ptr;

    lldma_regs u_regs (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy), .chain_done(chain_done), .daddr(daddr),
        .start(start), .daddr_we(daddr_we), .gen_en(gen_en),
        .dscr_ptr(dscr_ptr), .src_hw(src_hw), .dst_hw(dst_hw), .irq(irq)
    );

    lldma_engine u_eng (
        .clk(clk), .rst(rst),
        .start(start), .start_ptr(dscr_ptr),
        .daddr_we(daddr_we), .daddr_wdata(reg_wdata[ADDR_W-1:0]),
        .src_hw(src_hw), .dst_hw(dst_hw),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_gnt(mem_gnt),
        .src_req(src_req), .dst_req(dst_req),
        .src_ack(src_ack), .dst_ack(dst_ack),
        .busy(busy), .chain_done(chain_done), .daddr(daddr)
    );
endmodule

// File: rtl/lldma_checker.sv
module lldma_checker
    import lldma_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_gnt,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [1:0]        mem_size,
    input logic              src_ack,
    input logic              dst_ack,
    input logic              src_hw,
    input logic              dst_hw,
    input logic              busy,
    input logic              gen_en,
    input logic              irq,
    input logic              reg_re,
    input logic [2:0]        reg_addr
);
    p_start_gated_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(gen_en));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req);

    p_src_ack_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        src_ack |=> !src_ack);

    p_dst_ack_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        dst_ack |=> !dst_ack);

    p_src_sw_silent_r9: assert property (@(posedge clk) disable iff (rst)
        !src_hw |-> !src_ack);

    p_dst_sw_silent_r9: assert property (@(posedge clk) disable iff (rst)
        !dst_hw |-> !dst_ack);

    p_irq_when_idle_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> !busy);

    p_read_clears_r11: assert property (@(posedge clk) disable iff (rst)
        (reg_re && reg_addr == RA_ISR && !busy) |=> !irq);

    p_req_held_r13: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_size)));
endmodule

bind lldma_channel lldma_checker u_chk (
    .clk(clk), .rst(rst),
    .mem_req(mem_req), .mem_we(mem_we), .mem_gnt(mem_gnt),
    .mem_addr(mem_addr), .mem_size(mem_size),
    .src_ack(src_ack), .dst_ack(dst_ack),
    .src_hw(src_hw), .dst_hw(dst_hw),
    .busy(busy), .gen_en(gen_en), .irq(irq),
    .reg_re(reg_re), .reg_addr(reg_addr)
);

// File: tb/sim_lldma_channel.sv
module sim_lldma_channel;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0, reg_re = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0, reg_rdata;
    logic        mem_req, mem_we, mem_gnt;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  mem_size;
    logic        src_req = 1'b0, dst_req = 1'b0, src_ack, dst_ack, irq;

    int checks = 0, errors = 0;
    logic [7:0] mem  [0:1023];
    logic [7:0] expm [0:1023];
    logic [7:0] lfsr = 8'hA5;
    logic       gnt_all = 1'b0;
    int n_rd = 0, n_wr = 0, n_sack = 0, n_dack = 0;
    logic [31:0] fa [0:15];
    longint cyc = 0;

    always #4 clk = ~clk;

    lldma_channel u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_gnt(mem_gnt), .src_req(src_req), .src_ack(src_ack),
        .dst_req(dst_req), .dst_ack(dst_ack), .irq(irq)
    );

    // memory model
    logic [9:0] ma;
    assign ma = mem_addr[9:0];
    assign mem_gnt = gnt_all | lfsr[0];
    assign mem_rdata = {mem[ma + 10'd3], mem[ma + 10'd2], mem[ma + 10'd1], mem[ma]};

    always @(negedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req && mem_gnt) begin
            if (mem_we) begin
                n_wr <= n_wr + 1;
                mem[ma] <= mem_wdata[7:0];
                if (mem_size >= 2'd1) mem[ma + 10'd1] <= mem_wdata[15:8];
                if (mem_size >= 2'd2) begin
                    mem[ma + 10'd2] <= mem_wdata[23:16];
                    mem[ma + 10'd3] <= mem_wdata[31:24];
                end
            end else begin
                if (n_rd < 16) fa[n_rd] <= mem_addr;
                n_rd <= n_rd + 1;
            end
        end
        if (src_ack) n_sack <= n_sack + 1;
        if (dst_ack) n_dack <= n_dack + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: act cycles %0d exp below 150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: act 0x%0h exp 0x%0h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_re = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk); reg_re = 1'b0;
    endtask

    task automatic put_word(input int a, input logic [31:0] w);
        for (int k = 0; k < 4; k++) begin
            mem[(a + k) & 1023]  = w[8*k +: 8];
            expm[(a + k) & 1023] = w[8*k +: 8];
        end
    endtask

    task automatic fill(input int seed);
        for (int i = 0; i < 1024; i++) begin
            mem[i]  = 8'((i * 7 + seed * 13 + 3) & 255);
            expm[i] = mem[i];
        end
    endtask

    function automatic int nbytes(input int w);
        return (w == 0) ? 1 : (w == 1) ? 2 : 4;
    endfunction

    function automatic int stepv(input int w, input int m);
        return (m == 0) ? nbytes(w) : (m == 1) ? -nbytes(w) : 0;
    endfunction

    function automatic logic [31:0] exp_word(input int a);
        return {expm[(a+3) & 1023], expm[(a+2) & 1023], expm[(a+1) & 1023], expm[a & 1023]};
    endfunction

    // element-level reference model over expm; returns final destination address
    task automatic model(input int ptr0, input int d0, output int dfin);
        int p, d, s, sw, dw, sm, dm, cntv;
        logic [31:0] ca, cb, v;
        p = ptr0; d = d0;
        do begin
            s  = int'(exp_word(p));
            ca = exp_word(p + 12);
            cb = exp_word(p + 16);
            cntv = int'(ca[15:0]); sw = int'(ca[17:16]); dw = int'(ca[19:18]);
            sm = int'(cb[1:0]); dm = int'(cb[3:2]);
            for (int e = 0; e < cntv; e++) begin
                v = 0;
                for (int k = 0; k < nbytes(sw); k++) v[8*k +: 8] = expm[(s + k) & 1023];
                for (int k = 0; k < nbytes(dw); k++) expm[(d + k) & 1023] = v[8*k +: 8];
                s += stepv(sw, sm); d += stepv(dw, dm);
            end
            ca[31] = 1'b1;
            for (int k = 0; k < 4; k++) expm[(p + 12 + k) & 1023] = ca[8*k +: 8];
            p = int'(exp_word(p + 8));
        end while (p != 0);
        dfin = d;
    endtask

    task automatic mem_compare(input string tag);
        int bad, first;
        bad = 0; first = -1;
        for (int i = 0; i < 1024; i++)
            if (mem[i] !== expm[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        if (first < 0) check(1'b1, tag, 0, 0);
        else check(1'b0, {tag, " byte at ", $sformatf("0x%0h", first)}, mem[first], expm[first]);
    endtask

    task automatic wait_irq();
        while (!irq) @(negedge clk);
    endtask

    task automatic clear_counts();
        n_rd = 0; n_wr = 0; n_sack = 0; n_dack = 0;
    endtask

    logic [31:0] rv;
    int dfin, acks_exp, left, kch;
    bit seen;

    initial begin
        fill(0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        check(irq == 1'b0 && mem_req == 1'b0 && src_ack == 1'b0 && dst_ack == 1'b0, "R12 outputs after reset",
              {irq, mem_req, src_ack, dst_ack}, 0);
        for (int a = 0; a < 6; a++) begin
            reg_rd(3'(a), rv);
            check(rv == 0, $sformatf("R12 register %0d after reset", a), rv, 0);
        end

        // R1: enable without global enable does nothing
        put_word(12'h300, 32'h100); put_word(12'h304, 0); put_word(12'h308, 0);
        put_word(12'h30C, 32'h0000_0004); put_word(12'h310, 0);
        reg_wr(RA_DSCR_C, 32'h300);
        clear_counts();
        reg_wr(3'd1, 32'd1);
        repeat (30) @(negedge clk);
        check(n_rd == 0 && n_wr == 0, "R1 no traffic without global enable", n_rd + n_wr, 0);
        reg_rd(3'd1, rv);
        check(rv == 0, "R1 channel enable stays 0", rv, 0);
        reg_wr(3'd0, 32'd1);
        reg_rd(3'd0, rv);
        check(rv == 1, "R1 global enable readback", rv, 1);

        // R2 R3 R6 R7 R10 R11: three-descriptor chain
        fill(1);
        put_word(12'h300, 32'h100); put_word(12'h304, 32'hDEAD_0000); put_word(12'h308, 32'h320);
        put_word(12'h30C, 32'h0005_0003);  put_word(12'h310, 32'h0000_0010);   // sw=1 dw=1 count3
        put_word(12'h320, 32'h180); put_word(12'h324, 32'h0000_0000); put_word(12'h328, 32'h340);
        put_word(12'h32C, 32'h0008_0004);  put_word(12'h330, 32'h0000_0000);   // sw=0 dw=2 count4
        put_word(12'h340, 32'h1C0); put_word(12'h344, 32'h0000_0280); put_word(12'h348, 32'h0);
        put_word(12'h34C, 32'h000A_0002);  put_word(12'h350, 32'h0000_0000);   // sw=2 dw=2 count2
        model(12'h300, 12'h200, dfin);
        reg_wr(3'd3, 32'h200);
        reg_wr(3'd4, 32'd0);
        clear_counts();
        reg_wr(3'd1, 32'd1);
        reg_rd(3'd1, rv);
        check(rv == 1, "R1 channel busy after start", rv, 1);
        wait_irq();
        @(negedge clk);
        for (int k = 0; k < 5; k++)
            check(fa[k] == 32'h300 + 4 * k, $sformatf("R2 fetch order word %0d", k), fa[k], 32'h300 + 4 * k);
        mem_compare("R3 R6 R7 chained image");
        reg_rd(3'd3, rv);
        check(rv == 32'(dfin), "R3 running destination readback", rv, dfin);
        reg_rd(3'd1, rv);
        check(rv == 0, "R10 channel enable cleared", rv, 0);
        check(irq == 1'b1, "R10 interrupt raised", irq, 1);
        reg_rd(3'd5, rv);
        check(rv == 1, "R10 status bit set", rv, 1);
        check(irq == 1'b0, "R11 status read clears interrupt", irq, 0);

        // R8: hardware handshake both sides, chunk of 4, count 10
        fill(2);
        put_word(12'h300, 32'h100); put_word(12'h304, 0); put_word(12'h308, 0);
        put_word(12'h30C, 32'h000A_000A); put_word(12'h310, 32'h0000_0020);
        model(12'h300, 12'h200, dfin);
        reg_wr(3'd3, 32'h200);
        reg_wr(3'd4, 32'd3);
        src_req = 1'b0; dst_req = 1'b0;
        clear_counts();
        reg_wr(3'd1, 32'd1);
        repeat (80) @(negedge clk);
        check(n_rd == 5 && n_wr == 0, "R8 no data moved without requests", n_rd * 100 + n_wr, 500);
        src_req = 1'b1;
        repeat (20) @(negedge clk);
        check(n_wr == 0, "R8 destination request still missing", n_wr, 0);
        dst_req = 1'b1;
        wait_irq();
        @(negedge clk);
        acks_exp = 0; left = 10; kch = 4;
        while (left > 0) begin left -= (left >= kch) ? kch : 1; acks_exp++; end
        check(n_sack == acks_exp, "R8 source acknowledge count", n_sack, acks_exp);
        check(n_dack == acks_exp, "R8 destination acknowledge count", n_dack, acks_exp);
        mem_compare("R8 handshaked image");
        reg_rd(3'd5, rv);
        src_req = 1'b0; dst_req = 1'b0;
        reg_wr(3'd4, 32'd0);

        // R4 R5 R6 R9 R13: sweep widths and modes, random grants, software select
        clear_counts();
        for (int sw = 0; sw < 3; sw++)
            for (int dw = 0; dw < 3; dw++)
                for (int sm = 0; sm < 3; sm++)
                    for (int dm = 0; dm < 3; dm++) begin
                        fill(sw * 27 + dw * 9 + sm * 3 + dm);
                        put_word(12'h300, (sm == 1) ? 32'h140 : 32'h100);
                        put_word(12'h304, 32'hDEAD_0000);
                        put_word(12'h308, 0);
                        put_word(12'h30C, 32'(5 | (sw << 16) | (dw << 18)));
                        put_word(12'h310, 32'(sm | (dm << 2) | (1 << 4)));
                        model(12'h300, (dm == 1) ? 12'h240 : 12'h200, dfin);
                        reg_wr(3'd3, (dm == 1) ? 32'h240 : 32'h200);
                        reg_wr(3'd1, 32'd1);
                        wait_irq();
                        reg_rd(3'd5, rv);
                        mem_compare($sformatf("R4 R5 R6 R13 sw%0d dw%0d sm%0d dm%0d", sw, dw, sm, dm));
                        reg_rd(3'd3, rv);
                        check(rv == 32'(dfin), "R4 R5 final destination address", rv, dfin);
                    end
        check(n_sack == 0 && n_dack == 0, "R9 no acknowledges with software select", n_sack + n_dack, 0);

        // R11: completion coincides with a held status read
        fill(5);
        put_word(12'h300, 32'h100); put_word(12'h304, 0); put_word(12'h308, 0);
        put_word(12'h30C, 32'h000A_0003); put_word(12'h310, 0);
        reg_wr(3'd3, 32'h200);
        reg_wr(3'd1, 32'd1);
        @(negedge clk); reg_addr = 3'd5; reg_re = 1'b1;
        seen = 1'b0;
        for (int t = 0; t < 3000 && !seen; t++) begin
            @(negedge clk);
            if (irq) seen = 1'b1;
        end
        check(seen, "R11 completion wins over same-cycle read", seen, 1);
        @(negedge clk);
        reg_re = 1'b0;
        check(irq == 1'b0, "R11 held read clears afterwards", irq, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    localparam logic [2:0] RA_DSCR_C = 3'd2;
endmodule